// File: doc/BRIEF.md
# Cycle-Counting Overcurrent Fault Handler

This block decides when a multi-phase buck controller must stop switching because of overcurrent. Each phase's gate driver raises a current-limit flag. The block samples that flag once per switching cycle, on a strobe from the PWM timebase. A phase trips when its flag has been high for more switching cycles in a row than a programmable limit allows. A single switching cycle with the flag low starts that run again from zero. The driver holds its flag for one extra cycle after an overcurrent event. This does not change the block, because a held flag simply counts as another high cycle.

A second, slower path works on a 1 ms tick. It compares an averaged phase-current code with a threshold, and its response is selectable. The mode "ignore" has no effect. "Retry" starts a timed restart. "Delay" shuts down only after the condition has persisted for a set number of ticks. "Shutdown" latches off at once. A trip from the cycle counters goes to either timed restart or latch-off, chosen by one configuration bit. A trip on any phase stops the PWM outputs of all phases. During a timed restart the block waits a programmable number of ticks and then issues a one-cycle restart request. A latch-off lasts until the enable input goes low.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: While enabled and no fault is held, `pwm_off` is low one clock after `enable` is sampled high; on each `cyc_strobe` a phase whose flag is high advances its count by one.
- R2: A `cyc_strobe` with a phase's flag low clears that phase's count, so interrupted runs of flagged cycles never trip.
- R3: A phase trips on a strobe with its flag high when its count already equals or exceeds `cyc_limit`, i.e. on flagged cycle number `cyc_limit`+1 (with a limit of 0, on the first flagged cycle); `pwm_off` is high from the next clock.
- R4: With `cyc_latch` = 0, a cycle trip holds `pwm_off` high for exactly `hiccup_ticks` ticks (at least one), counted from the trip.
- R5: When that wait ends, `restart_req` is high for exactly one clock, `pwm_off` returns low in the same clock, and `phase_fault` is cleared.
- R6: With `cyc_latch` = 1, a cycle trip keeps `pwm_off` high and `phase_fault` set across any number of ticks without a restart, until `enable` is sampled low, which clears `phase_fault`.
- R7: `avg_mode` = 0 (ignore): average current above the threshold has no effect on the outputs.
- R8: `avg_mode` = 1 (retry): a tick with `avg_cur` strictly greater than `avg_thresh` starts the same timed restart as R4/R5, without setting `phase_fault`; a value equal to the threshold does nothing.
- R9: `avg_mode` = 2 (delay): the block latches off on the `avg_delay`-th consecutive tick with `avg_cur` above the threshold; a tick at or below the threshold restarts the count.
- R10: `avg_mode` = 3 (shutdown): a single tick above the threshold latches off.
- R11: `phase_fault` bit i is set by a trip of phase i only; simultaneous trips set both bits and one shared `pwm_off` disables all phases.
- R12: In reset, and whenever `enable` is low, `pwm_off` is high and `phase_fault` and `restart_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Output enabled; low clears any latch-off |
| cyc_strobe | input | 1 | One-clock pulse per switching cycle |
| tick_1ms | input | 1 | One-clock pulse per millisecond |
| ilim_flag | input | NPH | Per-phase current-limit flag from the drivers |
| avg_cur | input | CUR_W | Averaged phase-current code |
| cyc_limit | input | CNT_W | Allowed consecutive flagged cycles |
| cyc_latch | input | 1 | Cycle-trip response: 0 timed restart, 1 latch-off |
| avg_thresh | input | CUR_W | Average-current threshold |
| avg_mode | input | 2 | Average response: 0 ignore, 1 retry, 2 delay, 3 shutdown |
| avg_delay | input | TICK_W | Persistence ticks for the delay response |
| hiccup_ticks | input | TICK_W | Ticks to wait before a restart |
| pwm_off | output | 1 | High disables all PWM outputs |
| phase_fault | output | NPH | Per-phase cycle-trip status |
| restart_req | output | 1 | One-clock restart request |

## Verification
A per-phase count that fails to clear on a quiet switching cycle shows up as an early `pwm_off` rise, one clock after a strobe that should not have tripped. A count that runs short shows up as a missing rise on the strobe after the limit. A wrong wait counter in the restart state moves the single `restart_req` pulse by whole ticks, or makes it disappear. A persistence counter that is not cleared turns the interrupted delay pattern into a latch-off. All of these differences appear at the ports within one clock of the strobe or tick that exposes them.

// File: rtl/ocp_pkg.sv
// Package: shared state and response encodings for the overcurrent handler.
// Assumes: two-bit encodings are stable and decoded only inside this block.
package ocp_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_HICCUP = 2'd2,
        ST_LATCH  = 2'd3
    } ocp_state_t;

    typedef enum logic [1:0] {
        AVG_IGNORE   = 2'd0,
        AVG_RETRY    = 2'd1,
        AVG_DELAY    = 2'd2,
        AVG_SHUTDOWN = 2'd3
    } avg_resp_t;
endpackage

// File: rtl/ocp_cycle_counter.sv
// Module: consecutive flagged-cycle counter for one phase.
// What it does: counts switching cycles with the flag high; any quiet cycle
// clears the count; flags a trip when a flagged strobe finds count >= limit.
// Assumes: cyc_strobe is a single-clock pulse; armed is low whenever the
// outputs are off, so the count starts at zero after every restart.
module ocp_cycle_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             cyc_strobe,
    input  logic             flag,
    input  logic [CNT_W-1:0] limit,
    output logic             trip
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    // Count flagged cycles, saturating; clear on a quiet cycle or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!armed) begin
            cnt <= '0;
        end else if (cyc_strobe) begin
            if (!flag)
                cnt <= '0;
            else if (cnt != CNT_MAX)
                cnt <= cnt + CNT_W'(1);
        end
    end

    // Trip when this flagged cycle takes the run past the limit.
    always_comb begin
        trip = armed && cyc_strobe && flag && (cnt >= limit);
    end

    // R1: a flagged strobe advances the count by one.
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cyc_strobe && flag && cnt != CNT_MAX) |=> (cnt - $past(cnt) == CNT_W'(1)));

    // R2: a quiet strobe clears the count.
    assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && !flag) |=> (cnt == '0));
endmodule

// File: rtl/ocp_avg_monitor.sv
// Module: average-current threshold check with a selectable response.
// What it does: on each tick compares avg_cur with the threshold and emits a
// retry trip or a latch trip per the configured response; the delay response
// needs a run of over-threshold ticks before it latches.
// Assumes: tick is a single-clock pulse; armed is high only while running.
module ocp_avg_monitor
    import ocp_pkg::*;
#(
    parameter int CUR_W  = 10,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              tick,
    input  logic [CUR_W-1:0]  avg_cur,
    input  logic [CUR_W-1:0]  thresh,
    input  avg_resp_t         resp,
    input  logic [TICK_W-1:0] delay_ticks,
    output logic              trip_retry,
    output logic              trip_latch
);
    localparam int TW1 = TICK_W + 1;
    localparam logic [TICK_W-1:0] P_MAX = {TICK_W{1'b1}};

    logic              over;
    logic [TICK_W-1:0] pcnt;
    logic              persist_done;

    // Strictly-greater comparison and persistence test.
    always_comb begin
        over         = (avg_cur > thresh);
        persist_done = ({1'b0, pcnt} + TW1'(1)) >= {1'b0, delay_ticks};
    end

    // Count consecutive over-threshold ticks in delay mode; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!armed) begin
            pcnt <= '0;
        end else if (tick) begin
            if (over && resp == AVG_DELAY) begin
                if (pcnt != P_MAX)
                    pcnt <= pcnt + TICK_W'(1);
            end else begin
                pcnt <= '0;
            end
        end
    end

    // Decode the response into the two trip kinds.
    always_comb begin
        trip_retry = armed && tick && over && (resp == AVG_RETRY);
        trip_latch = armed && tick && over &&
                     ((resp == AVG_SHUTDOWN) || (resp == AVG_DELAY && persist_done));
    end

    // R9: a tick at or below the threshold restarts the persistence count.
    assert_persist_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !over) |=> (pcnt == '0));
endmodule

// File: rtl/ocp_fault_fsm.sv
// Module: response state machine shared by all phases.
// What it does: moves between off, running, timed restart and latch-off;
// keeps per-phase fault bits and emits the one-clock restart request.
// Assumes: trips arrive only while running; latch wins over restart when
// both arrive together; enable low overrides everything.
module ocp_fault_fsm
    import ocp_pkg::*;
#(
    parameter int NPH    = 2,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [NPH-1:0]    cyc_trip,
    input  logic              cyc_latch,
    input  logic              avg_retry,
    input  logic              avg_latch,
    input  logic [TICK_W-1:0] hiccup_ticks,
    output ocp_state_t        state,
    output logic [NPH-1:0]    phase_fault,
    output logic              restart_req
);
    localparam int TW1 = TICK_W + 1;

    ocp_state_t        state_nx;
    logic [TICK_W-1:0] wcnt;
    logic              any_cyc;
    logic              go_latch;
    logic              go_hiccup;
    logic              hic_done;

    // Trip classification and end-of-wait test.
    always_comb begin
        any_cyc   = |cyc_trip;
        go_latch  = avg_latch || (any_cyc && cyc_latch);
        go_hiccup = avg_retry || (any_cyc && !cyc_latch);
        hic_done  = tick && (({1'b0, wcnt} + TW1'(1)) >= {1'b0, hiccup_ticks});
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_OFF;
        end else begin
            case (state)
                ST_OFF:    state_nx = ST_RUN;
                ST_RUN:    if (go_latch) state_nx = ST_LATCH;
                           else if (go_hiccup) state_nx = ST_HICCUP;
                ST_HICCUP: if (hic_done) state_nx = ST_RUN;
                default:   state_nx = ST_LATCH;
            endcase
        end
    end

    // State, restart wait counter and restart pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OFF;
            wcnt        <= '0;
            restart_req <= 1'b0;
        end else begin
            state       <= state_nx;
            restart_req <= enable && (state == ST_HICCUP) && hic_done;
            if (state != ST_HICCUP)
                wcnt <= '0;
            else if (tick)
                wcnt <= wcnt + TICK_W'(1);
        end
    end

    // Per-phase fault bits: set by trips while running, cleared on restart or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_fault <= '0;
        end else if (!enable) begin
            phase_fault <= '0;
        end else if (state == ST_RUN) begin
            phase_fault <= phase_fault | cyc_trip;
        end else if (state == ST_HICCUP && hic_done) begin
            phase_fault <= '0;
        end
    end

    // R12: enable low always lands in the off state.
    assert_disable_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_OFF && phase_fault == '0));

    // R6: a latch-off persists while enable stays high.
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && enable) |=> (state == ST_LATCH && $stable(phase_fault)));

    // R5: a restart request only follows the timed-restart state.
    assert_restart_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> (state == ST_RUN && $past(state) == ST_HICCUP));

    // R4: between ticks the restart wait leaves fault bits and state alone.
    assert_wait_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HICCUP && enable && !tick) |=> (state == ST_HICCUP && $stable(phase_fault)));
endmodule

// File: rtl/ocp_fault_ctrl.sv
// Module: top of the overcurrent fault handler.
// What it does: one consecutive-cycle counter per phase, one average-current
// monitor and one shared response machine; drives a common PWM disable.
// Assumes: strobe and tick are single-clock pulses synchronous to clk;
// configuration inputs are quasi-static.
module ocp_fault_ctrl
    import ocp_pkg::*;
#(
    parameter int NPH    = 2,
    parameter int CNT_W  = 8,
    parameter int CUR_W  = 10,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cyc_strobe,
    input  logic              tick_1ms,
    input  logic [NPH-1:0]    ilim_flag,
    input  logic [CUR_W-1:0]  avg_cur,
    input  logic [CNT_W-1:0]  cyc_limit,
    input  logic              cyc_latch,
    input  logic [CUR_W-1:0]  avg_thresh,
    input  logic [1:0]        avg_mode,
    input  logic [TICK_W-1:0] avg_delay,
    input  logic [TICK_W-1:0] hiccup_ticks,
    output logic              pwm_off,
    output logic [NPH-1:0]    phase_fault,
    output logic              restart_req
);
    ocp_state_t     state;
    logic           armed;
    logic [NPH-1:0] cyc_trip;
    logic           avg_retry;
    logic           avg_latch;

    // Counters and monitor are live only while running.
    always_comb begin
        armed   = (state == ST_RUN);
        pwm_off = (state != ST_RUN);
    end

    // One consecutive-cycle counter per phase.
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        ocp_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .armed      (armed),
            .cyc_strobe (cyc_strobe),
            .flag       (ilim_flag[p]),
            .limit      (cyc_limit),
            .trip       (cyc_trip[p])
        );
    end

    ocp_avg_monitor #(.CUR_W(CUR_W), .TICK_W(TICK_W)) u_avg (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (armed),
        .tick        (tick_1ms),
        .avg_cur     (avg_cur),
        .thresh      (avg_thresh),
        .resp        (avg_resp_t'(avg_mode)),
        .delay_ticks (avg_delay),
        .trip_retry  (avg_retry),
        .trip_latch  (avg_latch)
    );

    ocp_fault_fsm #(.NPH(NPH), .TICK_W(TICK_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .tick         (tick_1ms),
        .cyc_trip     (cyc_trip),
        .cyc_latch    (cyc_latch),
        .avg_retry    (avg_retry),
        .avg_latch    (avg_latch),
        .hiccup_ticks (hiccup_ticks),
        .state        (state),
        .phase_fault  (phase_fault),
        .restart_req  (restart_req)
    );

    // R3/R11: any phase trip disables the shared PWM output on the next clock.
    assert_trip_blocks_pwm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|cyc_trip) |=> pwm_off);

    // R5: the restart request lasts a single clock.
    assert_restart_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    // R11: a fault bit is only raised by its own phase's trip.
    assert_fault_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (phase_fault & ~$past(phase_fault)) != '0) |->
            ((phase_fault & ~$past(phase_fault)) == $past(cyc_trip & ~phase_fault)));
endmodule

// File: tb/ocp_fault_ctrl_test.sv
`timescale 1ns/100ps
// Bench: scoreboard for ocp_fault_ctrl. Driver tasks push expected output
// items after each step; a monitor pops and compares them mid-cycle.
module ocp_fault_ctrl_test;
    localparam int NPH = 2, CNT_W = 8, CUR_W = 10, TICK_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              cyc_strobe = 1'b0;
    logic              tick_1ms = 1'b0;
    logic [NPH-1:0]    ilim_flag = '0;
    logic [CUR_W-1:0]  avg_cur = '0;
    logic [CNT_W-1:0]  cyc_limit = 8'd3;
    logic              cyc_latch = 1'b0;
    logic [CUR_W-1:0]  avg_thresh = 10'd500;
    logic [1:0]        avg_mode = 2'd0;
    logic [TICK_W-1:0] avg_delay = 8'd3;
    logic [TICK_W-1:0] hiccup_ticks = 8'd2;
    logic              pwm_off;
    logic [NPH-1:0]    phase_fault;
    logic              restart_req;

    ocp_fault_ctrl #(.NPH(NPH), .CNT_W(CNT_W), .CUR_W(CUR_W), .TICK_W(TICK_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_strobe(cyc_strobe),
        .tick_1ms(tick_1ms), .ilim_flag(ilim_flag), .avg_cur(avg_cur),
        .cyc_limit(cyc_limit), .cyc_latch(cyc_latch), .avg_thresh(avg_thresh),
        .avg_mode(avg_mode), .avg_delay(avg_delay), .hiccup_ticks(hiccup_ticks),
        .pwm_off(pwm_off), .phase_fault(phase_fault), .restart_req(restart_req)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        string          tag;
        logic           off;
        logic [NPH-1:0] flt;
        logic           rr;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Monitor: compare outputs against the oldest expectation.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (pwm_off !== e.off || phase_fault !== e.flt || restart_req !== e.rr) begin
                n_fail++;
                $display("FAIL %s: got off=%b flt=%b rr=%b, expected off=%b flt=%b rr=%b",
                         e.tag, pwm_off, phase_fault, restart_req, e.off, e.flt, e.rr);
            end
        end
    end

    task automatic expect_out(input string tag, input logic off,
                              input logic [NPH-1:0] flt, input logic rr);
        exp_t e;
        e.tag = tag; e.off = off; e.flt = flt; e.rr = rr;
        q.push_back(e);
        @(negedge clk);
    endtask

    // One switching cycle with the given flags.
    task automatic strobe(input logic [NPH-1:0] f);
        @(posedge clk); #1;
        ilim_flag = f; cyc_strobe = 1'b1;
        @(posedge clk); #1;
        cyc_strobe = 1'b0;
    endtask

    // One 1 ms tick with the given average current.
    task automatic tick(input logic [CUR_W-1:0] cur);
        @(posedge clk); #1;
        avg_cur = cur; tick_1ms = 1'b1;
        @(posedge clk); #1;
        tick_1ms = 1'b0;
    endtask

    task automatic set_enable(input logic v);
        @(posedge clk); #1;
        enable = v;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_out("R12 reset state", 1'b1, 2'b00, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        expect_out("R12 enable low", 1'b1, 2'b00, 1'b0);
        set_enable(1'b1);
        expect_out("R1 running after enable", 1'b0, 2'b00, 1'b0);

        // R2: interrupted runs never trip.
        for (int i = 0; i < 3; i++) strobe(2'b01);
        expect_out("R1 three flagged cycles at limit 3", 1'b0, 2'b00, 1'b0);
        strobe(2'b00);
        for (int i = 0; i < 3; i++) strobe(2'b01);
        expect_out("R2 quiet cycle cleared run", 1'b0, 2'b00, 1'b0);
        strobe(2'b01);
        expect_out("R3 fourth flagged cycle trips", 1'b1, 2'b01, 1'b0);

        // R4/R5: timed restart after two ticks.
        tick(10'd0);
        expect_out("R4 still waiting after one tick", 1'b1, 2'b01, 1'b0);
        tick(10'd0);
        expect_out("R5 restart pulse", 1'b0, 2'b00, 1'b1);
        @(posedge clk); #1;
        expect_out("R5 restart pulse single", 1'b0, 2'b00, 1'b0);
        strobe(2'b00);

        // R6: latch-off survives ticks, cleared by enable low.
        cyc_latch = 1'b1;
        for (int i = 0; i < 4; i++) strobe(2'b10);
        expect_out("R6 latch trip phase 1", 1'b1, 2'b10, 1'b0);
        for (int i = 0; i < 3; i++) tick(10'd0);
        expect_out("R6 latch holds across ticks", 1'b1, 2'b10, 1'b0);
        set_enable(1'b0);
        expect_out("R6 enable low clears latch", 1'b1, 2'b00, 1'b0);
        set_enable(1'b1);
        expect_out("R6 running again", 1'b0, 2'b00, 1'b0);
        strobe(2'b00);

        // R11: both phases trip together.
        cyc_latch = 1'b0;
        for (int i = 0; i < 4; i++) strobe(2'b11);
        expect_out("R11 both phases trip", 1'b1, 2'b11, 1'b0);
        tick(10'd0);
        tick(10'd0);
        expect_out("R11 shared restart", 1'b0, 2'b00, 1'b1);
        strobe(2'b00);

        // R3 corner: limit 0 trips on the first flagged cycle.
        cyc_limit = 8'd0;
        strobe(2'b10);
        expect_out("R3 limit zero trips at once", 1'b1, 2'b10, 1'b0);
        strobe(2'b00);
        tick(10'd0);
        tick(10'd0);
        expect_out("R4 restart after limit zero trip", 1'b0, 2'b00, 1'b1);
        cyc_limit = 8'd3;

        // R7: ignore mode.
        avg_mode = 2'd0;
        tick(10'd900);
        tick(10'd900);
        expect_out("R7 ignore has no effect", 1'b0, 2'b00, 1'b0);

        // R8: retry mode, equal value does nothing.
        avg_mode = 2'd1;
        tick(10'd500);
        expect_out("R8 equal to threshold ignored", 1'b0, 2'b00, 1'b0);
        tick(10'd501);
        expect_out("R8 retry entered", 1'b1, 2'b00, 1'b0);
        tick(10'd0);
        tick(10'd0);
        expect_out("R8 retry restart", 1'b0, 2'b00, 1'b1);

        // R9: delay mode persistence.
        avg_mode = 2'd2;
        tick(10'd900);
        tick(10'd900);
        expect_out("R9 two ticks over, not yet", 1'b0, 2'b00, 1'b0);
        tick(10'd100);
        tick(10'd900);
        tick(10'd900);
        expect_out("R9 count restarted by low tick", 1'b0, 2'b00, 1'b0);
        tick(10'd900);
        expect_out("R9 third consecutive tick latches", 1'b1, 2'b00, 1'b0);
        for (int i = 0; i < 3; i++) tick(10'd0);
        expect_out("R9 latched, no restart", 1'b1, 2'b00, 1'b0);
        set_enable(1'b0);
        set_enable(1'b1);
        expect_out("R12 re-enabled after delay latch", 1'b0, 2'b00, 1'b0);

        // R10: shutdown mode.
        avg_mode = 2'd3;
        tick(10'd501);
        expect_out("R10 shutdown on first tick", 1'b1, 2'b00, 1'b0);
        tick(10'd0);
        tick(10'd0);
        expect_out("R10 shutdown holds", 1'b1, 2'b00, 1'b0);

        @(posedge clk); @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule